// File: doc/BRIEF.md
# Spill-Sampled Correlated Double Sampler

This block turns buffered integrator readings from a pulsed beam into charge estimates. While the spill input is high, a shared 10-bit converter delivers samples. Each sample carries a channel number, and the block appends it to that channel's row of a sample bank. When the spill ends, the block waits for a trigger accept. It then walks every channel in turn and emits signed differences of stored samples. In single mode each difference is taken at a lag of two samples. In paired mode each difference compares two adjacent-pair sums. Each difference removes the slowly varying integrator baseline and leaves the charge that arrived in between.

Results leave on a valid/ready stream tagged with the channel and the sample (interval) index. Back-pressure is absorbed at the output register. While `out_valid` is high and `out_ready` is low, the data and tags hold still. The scan resumes on the cycle after a transfer. If no trigger accept arrives within `TRIG_WIN` cycles after the spill ends, the buffered spill is discarded. All control pins are plain levels.

Top module: `cds_spill_sampler`

## Requirements
- R1: After reset, `out_valid` is low and stays low until a trigger accept follows a captured spill.
- R2: A sample strobe is stored only while the block is capturing: from the cycle after `spill_active` rises, for as long as it stays high. Strobes at any other time have no effect on later outputs. Within a channel, sample index k is the k-th stored strobe, counting from 0.
- R3: In single mode (`pair_mode`=0), the block emits s[n]−s[n−2] for every n from 2 to count−1, with tag `out_idx`=n.
- R4: In paired mode (`pair_mode`=1), the block emits (s[n]+s[n+1])−(s[n−3]+s[n−2]) for every n from 3 to count−2, with tag `out_idx`=n. The range reaches ±2046 and has no saturation.
- R5: `out_data` is 12-bit two's complement, and single-mode results are sign-extended from 11 bits. Outputs come in ascending channel order, and by ascending n within a channel.
- R6: A channel with too few samples for a difference emits nothing for it. Samples from an earlier spill are never used.
- R7: A channel keeps only its first `DEPTH` samples per spill, and later strobes for it are dropped.
- R8: If `trig_accept` is not seen within `TRIG_WIN` cycles after the spill ends, the spill is discarded. A later trigger accept produces no output.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data`, `out_ch` and `out_idx` hold.
- R10: The mode is taken from `pair_mode` in the cycle the trigger accept is taken. Changes during readout have no effect.
- R11: A rising edge of `spill_active` while idle restarts every channel's write position at index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spill_active | input | 1 | High during the beam spill |
| samp_valid | input | 1 | Sample strobe |
| samp_ch | input | $clog2(NUM_CH) | Channel of the sample |
| samp_data | input | 10 | Unsigned integrator sample |
| pair_mode | input | 1 | 0 single lag-two, 1 paired sums |
| trig_accept | input | 1 | Releases the buffered spill for readout |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts the word |
| out_data | output | 12 | Signed difference |
| out_ch | output | $clog2(NUM_CH) | Channel tag |
| out_idx | output | $clog2(DEPTH) | Interval index n |

## Verification
The bench targets short spills of zero to three samples. A design that trusted the buffer instead of the per-spill count would emit differences built from the previous spill's leftovers. It drives one channel past `DEPTH` samples, where a missing fill guard would overwrite early samples and shift every difference. Paired mode runs under random back-pressure with samples at 1023 and 0, so it hits ±2046: a truncating datapath would wrap, and an output register that advanced without a handshake would skip or repeat words. Further cases are strobes sent between spill end and trigger, a mode flip right after the trigger, and a trigger arriving after the window has expired. Each of these would show up as extra, missing or reinterpreted words.

// File: rtl/cds_pkg.sv
package cds_pkg;
  localparam int SAMP_W = 10;
  localparam int DIFF_W = 12;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_CAPT = 2'd1,
    PH_WAIT = 2'd2,
    PH_READ = 2'd3
  } phase_e;
endpackage

// File: rtl/cds_sample_store.sv
module cds_sample_store
  import cds_pkg::*;
#(
  parameter int NUM_CH = 64,
  parameter int DEPTH  = 24,
  parameter int CH_W   = 6,
  parameter int AW     = 5,
  parameter int IW     = 6,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              wr_en,
  input  logic [CH_W-1:0]   wr_ch,
  input  logic [SAMP_W-1:0] wr_data,
  input  logic [CH_W-1:0]   rd_ch,
  input  logic [IW-1:0]     rd_idx  [4],
  output logic [SAMP_W-1:0] rd_data [4],
  output logic [CNT_W-1:0]  rd_cnt
);
  logic [SAMP_W-1:0] ch_rd   [NUM_CH][4];
  logic [CNT_W-1:0]  ch_fill [NUM_CH];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic [SAMP_W-1:0] bank [DEPTH];
    logic [CNT_W-1:0]  fill;
    logic              hit;
    logic              full;

    assign full = (fill == CNT_W'(DEPTH));
    assign hit  = wr_en && !clear && (wr_ch == CH_W'(g)) && !full;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     fill <= '0;
      else if (clear) fill <= '0;
      else if (hit)   fill <= fill + 1'b1;
    end

    always_ff @(posedge clk) begin
      if (hit) bank[fill[AW-1:0]] <= wr_data;
    end

    assign ch_fill[g] = fill;

    for (genvar k = 0; k < 4; k++) begin : g_rd
      assign ch_rd[g][k] = (rd_idx[k] < IW'(DEPTH)) ? bank[rd_idx[k][AW-1:0]] : '0;
    end

    // R7: a full channel ignores further strobes
    assert_full_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !clear && wr_ch == CH_W'(g) && full) |=> (fill == CNT_W'(DEPTH)));
    // R11: a clear always restarts the write position
    assert_clear_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (fill == '0));
  end

  for (genvar k = 0; k < 4; k++) begin : g_out
    assign rd_data[k] = ch_rd[rd_ch][k];
  end
  assign rd_cnt = ch_fill[rd_ch];
endmodule

// File: rtl/cds_phase_ctrl.sv
module cds_phase_ctrl
  import cds_pkg::*;
#(
  parameter int TRIG_WIN = 1000
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   spill_active,
  input  logic   trig_accept,
  input  logic   eng_done,
  output phase_e phase,
  output logic   buf_clear,
  output logic   wr_allow,
  output logic   eng_start
);
  localparam int TW_W = $clog2(TRIG_WIN + 1);

  logic            spill_q;
  logic [TW_W-1:0] timer;
  logic            spill_rise;
  logic            expire;

  assign spill_rise = spill_active && !spill_q;
  assign expire     = (phase == PH_WAIT) && !trig_accept && (timer == TW_W'(TRIG_WIN - 1));
  assign buf_clear  = ((phase == PH_IDLE) && spill_rise) || expire;
  assign wr_allow   = (phase == PH_CAPT) && spill_active;
  assign eng_start  = (phase == PH_WAIT) && trig_accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      spill_q <= 1'b0;
      timer   <= '0;
    end else begin
      spill_q <= spill_active;
      unique case (phase)
        PH_IDLE: if (spill_rise) phase <= PH_CAPT;
        PH_CAPT: if (!spill_active) begin
          phase <= PH_WAIT;
          timer <= '0;
        end
        PH_WAIT: begin
          if (trig_accept)  phase <= PH_READ;
          else if (expire)  phase <= PH_IDLE;
          else              timer <= timer + 1'b1;
        end
        PH_READ: if (eng_done) phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R2: capture closes on the cycle after the spill drops
  assert_capture_ends_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_CAPT && !spill_active) |=> (phase == PH_WAIT));
  // R5: readout begins only from a trigger taken while waiting
  assert_read_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_READ && $past(phase) != PH_READ) |-> ($past(phase) == PH_WAIT && $past(trig_accept)));
  // R8: leaving the wait phase for idle always discards the buffer
  assert_timeout_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE && $past(phase) == PH_WAIT) |-> $past(buf_clear));
endmodule

// File: rtl/cds_diff_engine.sv
module cds_diff_engine
  import cds_pkg::*;
#(
  parameter int NUM_CH = 64,
  parameter int DEPTH  = 24,
  parameter int CH_W   = 6,
  parameter int AW     = 5,
  parameter int IW     = 6,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              mode_in,
  input  logic [CNT_W-1:0]  rd_cnt,
  input  logic [SAMP_W-1:0] rd_data [4],
  output logic [CH_W-1:0]   rd_ch,
  output logic [IW-1:0]     rd_idx  [4],
  output logic              done,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [DIFF_W-1:0] m_data,
  output logic [CH_W-1:0]   m_ch,
  output logic [AW-1:0]     m_idx
);
  logic            busy;
  logic            mode_r;
  logic [CH_W-1:0] ch_r;
  logic [AW-1:0]   n_r;
  logic            step;
  logic            emit_ok;
  logic            last_n;
  logic            last_ch;
  logic [DIFF_W-1:0] d_single;
  logic [DIFF_W-1:0] d_paired;
  logic [IW-1:0]   n_ext;

  assign n_ext     = IW'(n_r);
  assign rd_ch     = ch_r;
  assign rd_idx[0] = n_ext;
  assign rd_idx[1] = n_ext + IW'(1);
  assign rd_idx[2] = n_ext - IW'(2);
  assign rd_idx[3] = n_ext - IW'(3);

  always_comb begin
    if (mode_r) emit_ok = (int'(n_r) >= 3) && (int'(n_r) + 1 < int'(rd_cnt));
    else        emit_ok = (int'(n_r) >= 2) && (int'(n_r) < int'(rd_cnt));
  end

  assign d_single = {2'b00, rd_data[0]} - {2'b00, rd_data[2]};
  assign d_paired = ({2'b00, rd_data[0]} + {2'b00, rd_data[1]})
                  - ({2'b00, rd_data[2]} + {2'b00, rd_data[3]});

  assign step    = busy && (!m_valid || m_ready);
  assign last_n  = (n_r == AW'(DEPTH - 1));
  assign last_ch = (ch_r == CH_W'(NUM_CH - 1));
  assign done    = step && last_n && last_ch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      mode_r <= 1'b0;
      ch_r   <= '0;
      n_r    <= '0;
    end else if (start) begin
      busy   <= 1'b1;
      mode_r <= mode_in;
      ch_r   <= '0;
      n_r    <= '0;
    end else if (step) begin
      if (last_n) begin
        n_r <= '0;
        if (last_ch) busy <= 1'b0;
        else         ch_r <= ch_r + 1'b1;
      end else begin
        n_r <= n_r + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_data  <= '0;
      m_ch    <= '0;
      m_idx   <= '0;
    end else if (step) begin
      m_valid <= emit_ok;
      if (emit_ok) begin
        m_data <= mode_r ? d_paired : d_single;
        m_ch   <= ch_r;
        m_idx  <= n_r;
      end
    end else if (!busy && m_valid && m_ready) begin
      m_valid <= 1'b0;
    end
  end

  // R9: a stalled word holds every field
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_ch) && $stable(m_idx)));
  // R6: no difference is ever tagged below the first computable index
  assert_min_index_R6: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> (int'(m_idx) >= 2));
  // R10: the latched mode cannot change during a scan
  assert_mode_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start) |=> $stable(mode_r));
  // R5: the scan never revisits an earlier channel
  assert_ch_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start && $past(busy)) |-> (ch_r >= $past(ch_r)));
endmodule

// File: rtl/cds_spill_sampler.sv
module cds_spill_sampler
  import cds_pkg::*;
#(
  parameter int NUM_CH   = 64,
  parameter int DEPTH    = 24,
  parameter int TRIG_WIN = 1000,
  localparam int CH_W    = $clog2(NUM_CH),
  localparam int AW      = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spill_active,
  input  logic              samp_valid,
  input  logic [CH_W-1:0]   samp_ch,
  input  logic [9:0]        samp_data,
  input  logic              pair_mode,
  input  logic              trig_accept,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [11:0]       out_data,
  output logic [CH_W-1:0]   out_ch,
  output logic [AW-1:0]     out_idx
);
  localparam int IW    = AW + 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  phase_e            phase;
  logic              buf_clear;
  logic              wr_allow;
  logic              eng_start;
  logic              eng_done;
  logic [CH_W-1:0]   rd_ch;
  logic [IW-1:0]     rd_idx  [4];
  logic [SAMP_W-1:0] rd_data [4];
  logic [CNT_W-1:0]  rd_cnt;

  cds_phase_ctrl #(.TRIG_WIN(TRIG_WIN)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .spill_active(spill_active),
    .trig_accept(trig_accept), .eng_done(eng_done), .phase(phase),
    .buf_clear(buf_clear), .wr_allow(wr_allow), .eng_start(eng_start)
  );

  cds_sample_store #(.NUM_CH(NUM_CH), .DEPTH(DEPTH), .CH_W(CH_W), .AW(AW),
                     .IW(IW), .CNT_W(CNT_W)) u_store (
    .clk(clk), .rst_n(rst_n), .clear(buf_clear),
    .wr_en(samp_valid && wr_allow), .wr_ch(samp_ch), .wr_data(samp_data),
    .rd_ch(rd_ch), .rd_idx(rd_idx), .rd_data(rd_data), .rd_cnt(rd_cnt)
  );

  cds_diff_engine #(.NUM_CH(NUM_CH), .DEPTH(DEPTH), .CH_W(CH_W), .AW(AW),
                    .IW(IW), .CNT_W(CNT_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(eng_start), .mode_in(pair_mode),
    .rd_cnt(rd_cnt), .rd_data(rd_data), .rd_ch(rd_ch), .rd_idx(rd_idx),
    .done(eng_done), .m_valid(out_valid), .m_ready(out_ready),
    .m_data(out_data), .m_ch(out_ch), .m_idx(out_idx)
  );

  // R1/R5: words only appear while reading out or draining the last one
  assert_valid_phase_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (phase == PH_READ));
endmodule

// File: tb/tb_cds_spill_sampler.sv
module tb_cds_spill_sampler;
  localparam int NCH = 4;
  localparam int DEP = 24;
  localparam int TW  = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       spill_active = 1'b0;
  logic       samp_valid = 1'b0;
  logic [1:0] samp_ch = '0;
  logic [9:0] samp_data = '0;
  logic       pair_mode = 1'b0;
  logic       trig_accept = 1'b0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [11:0] out_data;
  logic [1:0] out_ch;
  logic [4:0] out_idx;

  cds_spill_sampler #(.NUM_CH(NCH), .DEPTH(DEP), .TRIG_WIN(TW)) dut (
    .clk(clk), .rst_n(rst_n), .spill_active(spill_active), .samp_valid(samp_valid),
    .samp_ch(samp_ch), .samp_data(samp_data), .pair_mode(pair_mode),
    .trig_accept(trig_accept), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_ch(out_ch), .out_idx(out_idx)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int ref_s   [NCH][DEP];
  int ref_cnt [NCH];
  int got_data [256];
  int got_ch   [256];
  int got_idx  [256];
  int got_n = 0;
  bit bp_on = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  bit hold_prev = 1'b0;
  logic [11:0] h_data;
  logic [1:0]  h_ch;
  logic [4:0]  h_idx;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #2;
  endtask

  always @(posedge clk) begin
    #2;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready = bp_on ? lfsr[0] : 1'b1;
  end

  // collection and R9 hold check
  always @(negedge clk) begin
    if (rst_n) begin
      if (hold_prev) begin
        chk(out_valid && out_data == h_data && out_ch == h_ch && out_idx == h_idx,
            "R9 hold", int'(out_data), int'(h_data));
      end
      if (out_valid && out_ready && got_n < 256) begin
        got_data[got_n] = int'($signed(out_data));
        got_ch[got_n]   = int'(out_ch);
        got_idx[got_n]  = int'(out_idx);
        got_n++;
      end
      hold_prev = out_valid && !out_ready;
      h_data = out_data; h_ch = out_ch; h_idx = out_idx;
    end
  end

  function automatic int fval(int ch, int n);
    if (ch == 0) begin
      if (n % 6 < 2) return 1023;
      else if (n % 6 == 2) return 500;
      else return 0;
    end
    return (ch * 211 + n * n * 37 + n * 5) % 1024;
  endfunction

  task automatic start_spill();
    for (int c = 0; c < NCH; c++) ref_cnt[c] = 0;
    spill_active = 1'b1;
    tick(); tick();
  endtask

  task automatic push(input int ch, input int val, input bit model);
    samp_valid = 1'b1; samp_ch = 2'(ch); samp_data = 10'(val);
    tick();
    samp_valid = 1'b0;
    if (model && ref_cnt[ch] < DEP) begin
      ref_s[ch][ref_cnt[ch]] = val;
      ref_cnt[ch]++;
    end
  endtask

  task automatic end_spill();
    spill_active = 1'b0;
    tick(); tick();
  endtask

  task automatic readout(input bit mode);
    got_n = 0;
    pair_mode = mode; trig_accept = 1'b1;
    tick();
    trig_accept = 1'b0; pair_mode = ~mode;  // R10: late change must not matter
    repeat (NCH * DEP * 6 + 40) tick();
  endtask

  task automatic compare(input bit mode, input string req);
    int k = 0;
    for (int c = 0; c < NCH; c++) begin
      for (int n = 0; n < DEP; n++) begin
        bit ok;
        int e;
        ok = mode ? (n >= 3 && n + 1 < ref_cnt[c]) : (n >= 2 && n < ref_cnt[c]);
        if (ok) begin
          e = mode ? (ref_s[c][n] + ref_s[c][n+1] - ref_s[c][n-3] - ref_s[c][n-2])
                   : (ref_s[c][n] - ref_s[c][n-2]);
          if (k < got_n) begin
            chk(got_data[k] == e, {req, " data"}, got_data[k], e);
            chk(got_ch[k] == c && got_idx[k] == n, "R5 order/tag",
                got_ch[k] * 100 + got_idx[k], c * 100 + n);
          end
          k++;
        end
      end
    end
    chk(got_n == k, {req, " word count"}, got_n, k);
  endtask

  task automatic t_reset();
    chk(out_valid == 1'b0, "R1 reset valid", int'(out_valid), 0);
  endtask

  task automatic t_single();
    start_spill();
    for (int n = 0; n < 20; n++)
      for (int c = 0; c < NCH; c++) push(c, fval(c, n), 1'b1);
    end_spill();
    chk(out_valid == 1'b0, "R1 no word before trigger", int'(out_valid), 0);
    readout(1'b0);
    compare(1'b0, "R3 single");
  endtask

  task automatic t_paired_bp();
    bp_on = 1'b1;
    start_spill();
    for (int n = 0; n < 21; n++)
      for (int c = 0; c < NCH; c++) push(c, fval(c, n), 1'b1);
    end_spill();
    readout(1'b1);
    compare(1'b1, "R4 paired R10");
    bp_on = 1'b0;
  endtask

  task automatic t_short();
    start_spill();
    push(0, 700, 1'b1); push(0, 3, 1'b1);
    push(1, 10, 1'b1); push(1, 900, 1'b1); push(1, 1023, 1'b1);
    push(3, 55, 1'b1);
    end_spill();
    push(0, 999, 1'b0); push(3, 1, 1'b0); push(3, 2, 1'b0);  // R2: ignored strobes
    readout(1'b0);
    compare(1'b0, "R6 R11 R2 short");
  endtask

  task automatic t_overflow();
    start_spill();
    for (int n = 0; n < DEP + 4; n++) push(2, fval(2, n + 3), 1'b1);
    push(1, 4, 1'b1); push(1, 8, 1'b1); push(1, 1000, 1'b1); push(1, 0, 1'b1);
    end_spill();
    readout(1'b0);
    compare(1'b0, "R7 overflow");
  endtask

  task automatic t_timeout();
    start_spill();
    for (int n = 0; n < 8; n++) push(1, fval(1, n), 1'b1);
    end_spill();
    repeat (2 * TW) tick();
    got_n = 0;
    trig_accept = 1'b1; tick(); trig_accept = 1'b0;
    repeat (NCH * DEP + 40) tick();
    chk(got_n == 0, "R8 discarded after window", got_n, 0);
    chk(out_valid == 1'b0, "R8 valid low", int'(out_valid), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", checks + 1, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    t_reset();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_single();
    t_paired_bp();
    t_short();
    t_overflow();
    t_timeout();
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule